// File: doc/BRIEF.md
# Nonvolatile Array Program/Erase Sequencer

This block runs the write side of a small byte-wide nonvolatile array that is held as a register array. Software talks to it over a simple write/read bus. A control register sits at one address and the array occupies a window of addresses. To change the array, software first arms an address/data capture. It then writes to the array window, which captures a target but does not touch the cells. Next it sets the enable bit, which starts an internal operation timer. The operation lands when the timer has run out. If the auto bit is set, the block finishes on its own. If it is clear, the operation lands only when software drops the enable bit after expiry. Dropping the enable bit earlier aborts the operation.

Four kinds of operation are supported. A byte program ANDs the new data into the cell. A byte erase, a block erase and a bulk erase each set the affected bytes to 0xFF. A configuration input carries one protect bit per 128-byte block, and a protected block never changes. The register interlocks force the capture to be armed before the enable bit can be set, and they keep the capture armed while an operation is running.

Top module: `eeprom_seq`

## Requirements
- R1: After reset the control register reads 0x00, `busy` is low, and every array byte reads 0xFF.
- R2: Control register encoding: bit 0 is the enable bit, bit 1 arms the capture, bit 2 is the auto bit, and bits 4:3 select the operation (0 program, 1 byte erase, 2 block erase, 3 bulk erase). Bits 7:5 read 0. While the capture bit is clear, a write to the array window has no effect, and a read of the window returns the stored cell.
- R3: While the capture bit is set and `busy` is low, each array-window write replaces the captured offset and data. Only the last such write is used. Cells do not change.
- R4: While the capture bit is set, a read of any window address returns the captured data. When `busy` is low, that read also replaces the captured offset with the one read.
- R5: The enable bit is accepted only if the capture bit was already set before that write and at least one window access has been captured since then. One write cannot set both bits from idle.
- R6: While the enable bit is set, the capture bit cannot be cleared. A write of 0x00 at that time clears only the enable bit.
- R7: `busy` follows the enable bit. With the auto bit set, the enable bit clears by itself on the (OP_CYCLES+1)th clock edge after the edge that set it, and the operation is applied on that same edge.
- R8: With the auto bit clear, a control write that clears the enable bit commits the operation if it is sampled on or after the (OP_CYCLES+1)th edge. If it is sampled any earlier, the operation is aborted and no cell changes.
- R9: A program sets cell = cell AND data. A byte erase sets the captured byte to 0xFF. A block erase sets the 128-byte block holding the captured offset to 0xFF. A bulk erase sets every byte to 0xFF.
- R10: Bit k of `protCfg` guards array offsets k*128 to k*128+127. Bytes in a guarded block are left unchanged by every operation, and a bulk erase skips guarded blocks.
- R11: While `busy` is high, writes to the array window are ignored, and control writes cannot change the auto bit or the operation field.
- R12: If an auto completion and a control write fall on the same edge, the completion wins. The enable bit clears whatever the written enable value is, and the operation is applied once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (used to capture read addresses) |
| busAddr | input | 16 | Bus address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| protCfg | input | 4 | Per-block protect bits, 1 = guarded |
| busy | output | 1 | High while an operation is enabled |

## Verification
Two functions can meet on one clock edge. The first is the auto completion driven by the internal timer. The second is a software write to the control register, either a write that tries to keep the enable bit set or a write that clears it by hand. The bench counts edges from the write that set the enable bit, so it can place a control write exactly on the expiry edge. It judges the outcome from the control register readback and from the single value left in the target cell. The same edge counting places a manual clear one edge before expiry and exactly on expiry, to separate an abort from a commit.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG        = 2'd0,
    OP_BYTE_ERASE  = 2'd1,
    OP_BLOCK_ERASE = 2'd2,
    OP_BULK_ERASE  = 2'd3
  } opMode_e;

  // strobes from the control unit to the array datapath
  typedef struct packed {
    logic    capWrite;  // capture offset and data
    logic    capRead;   // capture offset only
    logic    commit;    // apply the pending operation this edge
    logic    latchOn;   // capture armed: reads return captured data
    opMode_e mode;
  } seqStrobe_t;

  localparam int CB_PGM   = 0;
  localparam int CB_LATCH = 1;
  localparam int CB_AUTO  = 2;
  localparam int CB_MODE  = 3;  // two bits

endpackage

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
#(
  parameter int OP_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [4:0] ctrlWdata,
  input  logic       arrWr,
  input  logic       arrRd,
  output seqStrobe_t strb,
  output logic [7:0] ctrlRdata,
  output logic       busy
);

  localparam int TW = $clog2(OP_CYCLES + 1);

  logic          pgmEn;
  logic          latchEn;
  logic          autoEn;
  opMode_e       modeQ;
  logic          latchValid;
  logic [TW-1:0] timer;

  logic expired;
  logic autoDone;
  logic swClear;
  logic startReq;
  logic latchNext;

  assign expired   = (timer == '0);
  assign autoDone  = pgmEn & autoEn & expired;
  assign swClear   = pgmEn & ctrlWr & ~ctrlWdata[CB_PGM] & ~autoDone;
  assign startReq  = ~pgmEn & ctrlWr & ctrlWdata[CB_PGM] & latchEn & latchValid;
  assign latchNext = ctrlWdata[CB_LATCH] | startReq;

  always_comb begin
    strb.capWrite = arrWr & latchEn & ~pgmEn;
    strb.capRead  = arrRd & latchEn & ~pgmEn;
    strb.commit   = autoDone | (swClear & expired);
    strb.latchOn  = latchEn;
    strb.mode     = modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmEn      <= 1'b0;
      latchEn    <= 1'b0;
      autoEn     <= 1'b0;
      modeQ      <= OP_PROG;
      latchValid <= 1'b0;
      timer      <= '0;
    end else if (pgmEn) begin
      if (autoDone || swClear) pgmEn <= 1'b0;
      if (!expired) timer <= timer - 1'b1;
    end else if (ctrlWr) begin
      pgmEn   <= startReq;
      latchEn <= latchNext;
      autoEn  <= ctrlWdata[CB_AUTO];
      modeQ   <= opMode_e'(ctrlWdata[CB_MODE +: 2]);
      if (!latchNext) latchValid <= 1'b0;
      if (startReq) timer <= TW'(OP_CYCLES);
    end else if (strb.capWrite || strb.capRead) begin
      latchValid <= 1'b1;
    end
  end

  assign ctrlRdata = {3'b000, modeQ, autoEn, latchEn, pgmEn};
  assign busy      = pgmEn;

  // R5: a running operation always has an armed, filled capture
  a_r5_enable_needs_latch: assert property (@(posedge clk) disable iff (!rstN)
    pgmEn |-> (latchEn && latchValid));

  // R6: the capture bit survives any edge where the enable bit was set
  a_r6_latch_held: assert property (@(posedge clk) disable iff (!rstN)
    pgmEn |=> latchEn);

  // R7: the timer starts full when the enable bit rises
  a_r7_timer_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgmEn) |-> (timer == TW'(OP_CYCLES)));

  // R7: auto completion releases the enable bit
  a_r7_auto_release: assert property (@(posedge clk) disable iff (!rstN)
    (pgmEn && autoEn && timer == '0) |=> !pgmEn);

  // R11: the operation field is frozen while running
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pgmEn |=> ($stable(modeQ) && $stable(autoEn)));

endmodule

// File: rtl/eeseq_dp.sv
module eeseq_dp
  import eeseq_pkg::*;
#(
  parameter int ARRAY_BYTES = 512,
  parameter int BLOCK_BYTES = 128,
  localparam int AW   = $clog2(ARRAY_BYTES),
  localparam int BSH  = $clog2(BLOCK_BYTES),
  localparam int BW   = AW - BSH,
  localparam int NBLK = ARRAY_BYTES / BLOCK_BYTES
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strb,
  input  logic [AW-1:0]   idx,
  input  logic [7:0]      wdata,
  input  logic [NBLK-1:0] protCfg,
  output logic [7:0]      arrRdata
);

  logic [AW-1:0] latchAddr;
  logic [7:0]    latchData;
  logic [7:0]    memArr   [ARRAY_BYTES];
  logic [7:0]    cellNext [ARRAY_BYTES];
  logic          cellWe   [ARRAY_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchAddr <= '0;
      latchData <= 8'hFF;
    end else if (strb.capWrite) begin
      latchAddr <= idx;
      latchData <= wdata;
    end else if (strb.capRead) begin
      latchAddr <= idx;
    end
  end

  for (genvar i = 0; i < ARRAY_BYTES; i++) begin : g_cell
    localparam int BLK = i / BLOCK_BYTES;
    logic hit;
    always_comb begin
      unique case (strb.mode)
        OP_PROG, OP_BYTE_ERASE: hit = (latchAddr == AW'(i));
        OP_BLOCK_ERASE:         hit = (latchAddr[AW-1:BSH] == BW'(BLK));
        default:                hit = 1'b1;
      endcase
    end
    assign cellWe[i]   = strb.commit & hit & ~protCfg[BLK];
    assign cellNext[i] = (strb.mode == OP_PROG) ? (memArr[i] & latchData) : 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ARRAY_BYTES; i++) begin
      if (!rstN)          memArr[i] <= 8'hFF;
      else if (cellWe[i]) memArr[i] <= cellNext[i];
    end
  end

  assign arrRdata = strb.latchOn ? latchData : memArr[idx];

  // R10: a guarded target byte never changes on commit
  a_r10_protected_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && protCfg[latchAddr[AW-1:BSH]]) |=> $stable(memArr[latchAddr]));

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeseq_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h0800,
  parameter logic [15:0] CTRL_ADDR   = 16'hFE1D,
  parameter int          ARRAY_BYTES = 512,
  parameter int          BLOCK_BYTES = 128,
  parameter int          OP_CYCLES   = 40,
  localparam int         AW          = $clog2(ARRAY_BYTES),
  localparam int         NBLK        = ARRAY_BYTES / BLOCK_BYTES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWe,
  input  logic            busRe,
  input  logic [15:0]     busAddr,
  input  logic [7:0]      busWdata,
  output logic [7:0]      busRdata,
  input  logic [NBLK-1:0] protCfg,
  output logic            busy
);

  logic [16:0] relAddr;
  logic        inWin;
  logic        ctrlHit;
  logic [7:0]  ctrlRdata;
  logic [7:0]  arrRdata;
  seqStrobe_t  strb;

  assign relAddr = {1'b0, busAddr} - {1'b0, BASE_ADDR};
  assign inWin   = (relAddr < 17'(ARRAY_BYTES));
  assign ctrlHit = (busAddr == CTRL_ADDR);

  eeseq_ctrl #(.OP_CYCLES(OP_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (busWe & ctrlHit),
    .ctrlWdata (busWdata[4:0]),
    .arrWr     (busWe & inWin),
    .arrRd     (busRe & inWin),
    .strb      (strb),
    .ctrlRdata (ctrlRdata),
    .busy      (busy)
  );

  eeseq_dp #(.ARRAY_BYTES(ARRAY_BYTES), .BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .idx      (relAddr[AW-1:0]),
    .wdata    (busWdata),
    .protCfg  (protCfg),
    .arrRdata (arrRdata)
  );

  assign busRdata = ctrlHit ? ctrlRdata : (inWin ? arrRdata : 8'h00);

endmodule

// File: tb/tb_eeprom_seq.sv
`timescale 1ns/100ps
module tb_eeprom_seq;

  localparam logic [15:0] BASE = 16'h0800;
  localparam logic [15:0] CTRL = 16'hFE1D;
  localparam int NB  = 512;
  localparam int OPC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [3:0]  protCfg = '0;
  logic        busy;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] refMem [NB];

  always #2.5 clk = ~clk;

  eeprom_seq dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .protCfg(protCfg), .busy(busy));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); busRe = 1'b1; busAddr = a; #1 d = busRdata;
    @(negedge clk); busRe = 1'b0;
  endtask

  task automatic chkRd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  function automatic void applyOp(input int la, input logic [7:0] ld,
                                  input int mode, input logic [3:0] prot);
    for (int i = 0; i < NB; i++) begin
      bit hit;
      case (mode)
        0, 1:    hit = (i == la);
        2:       hit = (i / 128 == la / 128);
        default: hit = 1'b1;
      endcase
      if (hit && !prot[i / 128]) refMem[i] = (mode == 0) ? (refMem[i] & ld) : 8'hFF;
    end
  endfunction

  function automatic logic [7:0] ctl(input int mode, input bit au, input bit la, input bit pg);
    return {3'b000, 2'(mode), au, la, pg};
  endfunction

  task automatic sweep(input string tag);
    for (int i = 0; i < NB; i++) chkRd(BASE + 16'(i), refMem[i], tag);
  endtask

  // wait for auto completion, bounded
  task automatic waitIdle(input string tag);
    for (int w = 0; w < OPC + 6 && busy; w++) @(negedge clk);
    chk({7'b0, busy}, 8'h00, tag);
  endtask

  task automatic randomOp();
    int mode, la, nw, r;
    bit au;
    logic [7:0] ld, v;
    logic [3:0] prot;
    r = $urandom % 8;
    mode = (r < 4) ? 0 : r - 4;
    au = 1'($urandom % 2);
    prot = 4'($urandom % 16) & 4'($urandom % 16);
    protCfg = prot;
    wr(CTRL, ctl(mode, au, 1, 0));
    nw = 1 + $urandom % 3;
    la = 0; ld = 0;
    for (int k = 0; k < nw; k++) begin
      la = $urandom % NB; ld = 8'($urandom);
      wr(BASE + 16'(la), ld);
    end
    if ($urandom % 2) begin
      la = $urandom % NB;
      rd(BASE + 16'(la), v);
      chk(v, ld, "R4 random latched read");
    end
    wr(CTRL, ctl(mode, au, 1, 1));
    chk({7'b0, busy}, 8'h01, "R7 busy after enable");
    if (au) waitIdle("R7 auto completion");
    else begin
      repeat (OPC) @(negedge clk);
      wr(CTRL, ctl(mode, 0, 1, 0));
    end
    applyOp(la, ld, mode, prot);
    wr(CTRL, 8'h00);
    chkRd(CTRL, 8'h00, "R6 idle after release");
    chkRd(BASE + 16'(la), refMem[la], "R9 random target");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int unsigned seed;
    seed = $urandom(32'd5150);
    for (int i = 0; i < NB; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkRd(CTRL, 8'h00, "R1 ctrl reset");
    chk({7'b0, busy}, 8'h00, "R1 busy reset");
    chkRd(BASE + 16'd300, 8'hFF, "R1 array reset");

    // R2 window write ignored with capture clear
    wr(BASE + 16'd5, 8'h12);
    chkRd(BASE + 16'd5, 8'hFF, "R2 write ignored");
    chkRd(16'h0000, 8'h00, "R2 unmapped");

    // R5 both bits from idle; enable without captured address
    wr(CTRL, 8'h03);
    chkRd(CTRL, 8'h02, "R5 same-write enable rejected");
    wr(CTRL, 8'h03);
    chkRd(CTRL, 8'h02, "R5 enable without capture rejected");

    // R3 last wins, R4 read override
    wr(BASE + 16'd10, 8'h5A);
    wr(BASE + 16'd20, 8'h3C);
    chkRd(BASE + 16'd10, 8'h3C, "R4 read returns captured data");
    wr(CTRL, 8'h03);
    // R8 clear one edge early: abort
    repeat (OPC - 2) @(negedge clk);
    chk({7'b0, busy}, 8'h01, "R7 busy before expiry");
    wr(CTRL, 8'h00);
    chkRd(CTRL, 8'h02, "R6 zero write clears enable only");
    wr(CTRL, 8'h03);
    repeat (OPC - 1) @(negedge clk);
    wr(CTRL, 8'h00);
    applyOp(10, 8'h3C, 0, 4'h0);
    wr(CTRL, 8'h00);
    chkRd(BASE + 16'd10, 8'h3C, "R8 commit on expiry edge");
    chkRd(BASE + 16'd20, 8'hFF, "R3 superseded write unused");

    // R12 auto completion meets a control write keeping enable set
    wr(CTRL, 8'h06);
    wr(BASE + 16'd40, 8'h0F);
    wr(CTRL, 8'h07);
    repeat (OPC - 1) @(negedge clk);
    chk({7'b0, busy}, 8'h01, "R7 busy until expiry");
    wr(CTRL, 8'h07);
    applyOp(40, 8'h0F, 0, 4'h0);
    chkRd(CTRL, 8'h06, "R12 auto wins enable clears");
    wr(CTRL, 8'h00);
    chkRd(BASE + 16'd40, 8'h0F, "R12 applied once");

    // R10 protection: program 130, then guarded erase keeps it
    wr(CTRL, 8'h06); wr(BASE + 16'd130, 8'h00); wr(CTRL, 8'h07);
    waitIdle("R7 auto done");
    applyOp(130, 8'h00, 0, 4'h0);
    wr(CTRL, 8'h00);
    protCfg = 4'b0010;
    wr(CTRL, 8'h0E); wr(BASE + 16'd130, 8'h77); wr(CTRL, 8'h0F);
    waitIdle("R7 auto done");
    wr(CTRL, 8'h00);
    chkRd(BASE + 16'd130, 8'h00, "R10 guarded byte erase");

    // R11 interference while busy, manual program
    wr(CTRL, 8'h02); wr(BASE + 16'd5, 8'hF0); wr(CTRL, 8'h03);
    wr(BASE + 16'd300, 8'h00);
    wr(CTRL, 8'h1F);
    chkRd(CTRL, 8'h03, "R11 mode and auto frozen");
    repeat (OPC) @(negedge clk);
    wr(CTRL, 8'h02);
    applyOp(5, 8'hF0, 0, 4'b0010);
    wr(CTRL, 8'h00);
    chkRd(BASE + 16'd5, 8'hF0, "R11 target kept");
    chkRd(BASE + 16'd300, 8'hFF, "R11 busy write ignored");

    // R9/R10 bulk erase skips guarded block
    wr(CTRL, 8'h1E); wr(BASE + 16'd7, 8'h00); wr(CTRL, 8'h1F);
    waitIdle("R7 auto done");
    applyOp(7, 8'h00, 3, 4'b0010);
    wr(CTRL, 8'h00);
    chkRd(BASE + 16'd40, 8'hFF, "R9 bulk erased");
    chkRd(BASE + 16'd130, 8'h00, "R10 bulk skipped guarded");
    sweep("R9 directed sweep");

    for (int n = 0; n < 40; n++) begin
      randomOp();
      if (n % 10 == 9) sweep("R9 R10 random sweep");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule